// File: doc/BRIEF.md
# Snoop-Aware Pending Coherence Request Queue

This block keeps one processor's coherence requests that have missed in its cache and must still go out on the shared atomic bus. Each entry holds a line address, the kind of bus request (read, read-exclusive or upgrade) and the transient state the line is in while it waits. The oldest entry that has not been launched is offered to the bus arbiter. An entry stays in the queue after it is granted, until a completion for its slot reports the stable state the line ends up in.

Every snooped bus address is compared with all live entries in the same cycle. A remote upgrade or read-exclusive can hit a local upgrade that has not been launched yet. In that case the local copy has gone stale, so the entry turns itself into a read-exclusive and its transient state moves from S→M to I→M. The snoop path is purely combinational on the stored entries and never waits on the arbiter. A processor that is blocked on its own request can therefore still answer the snoops that other processors are blocked on.

Top module: `pend_req_queue`

## Requirements
- R1: After reset no slot is live: `bus_req` is 0, `commit_mask` is 0, and a snoop reports no hit.
- R2: An enqueue is taken (`enq_accept`=1) when fewer than DEPTH (16) slots are live and no live slot holds the same address. It goes to the lowest-numbered free slot, which `enq_idx` shows. Request codes are 0 = read, 1 = read-exclusive, 2 = upgrade.
- R3: An enqueue to a full queue, or to an address that a live slot already holds, is refused (`enq_busy`=1, `enq_accept`=0) and changes nothing. Full and duplicate are judged on the state before the clock edge.
- R4: Slots are offered to the arbiter in enqueue order. `bus_req`, `bus_idx`, `bus_addr`, `bus_type` and `bus_trans` describe the oldest slot that has not been launched. Transient codes are 0 = I→S/E (read), 1 = I→M (read-exclusive), 2 = S→M (upgrade).
- R5: `snoop_hit` is 1 in the same cycle as `snoop_valid` whenever any live slot holds `snoop_addr`, whatever the state of the bus handshake.
- R6: A snoop of type 1 or 2 that hits a live, unlaunched upgrade turns that slot into read-exclusive with transient code 1 and pulses `snoop_inval`. When the slot is the head, `bus_type` shows read-exclusive in that same cycle, so a grant in that cycle launches it as read-exclusive.
- R7: A snoop that is a read, or that hits a slot already holding a read or read-exclusive, or that hits a launched slot, leaves the request type unchanged. It raises only `snoop_hit`.
- R8: `bus_grant` while `bus_req` is 1 launches the head slot. Its `commit_mask` bit is 1 from the next cycle, and the next oldest slot becomes the head. A grant while `bus_req` is 0 has no effect.
- R9: `cmpl_valid` for a launched slot gives `done_valid`=1 in the same cycle with that slot's address and stable state. The state is 3 (M) for read-exclusive or upgrade, and for a read it is 2 (E) if `cmpl_excl` is set, otherwise 1 (S). The slot is free from the next cycle.
- R10: A completion naming a slot that is not live, or is live but not launched, gives `done_valid`=0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | New request from the tag lookup |
| enq_addr | input | ADDR_W | Line address of the new request |
| enq_type | input | 2 | Request code of the new request |
| enq_accept | output | 1 | Request taken this cycle |
| enq_busy | output | 1 | Request refused (full or duplicate) |
| enq_idx | output | IDX_W | Slot the request is written to |
| bus_req | output | 1 | An unlaunched slot is waiting for the bus |
| bus_addr | output | ADDR_W | Address of the head slot |
| bus_type | output | 2 | Request code to launch, including a same-cycle conversion |
| bus_trans | output | 2 | Transient code of the head slot |
| bus_idx | output | IDX_W | Slot number of the head |
| bus_grant | input | 1 | Arbiter grant for the head slot |
| snoop_valid | input | 1 | A remote transaction is on the bus |
| snoop_addr | input | ADDR_W | Line address of the remote transaction |
| snoop_type | input | 2 | Request code of the remote transaction |
| snoop_hit | output | 1 | Snooped address matches a live slot |
| snoop_inval | output | 1 | A pending upgrade was turned into read-exclusive |
| cmpl_valid | input | 1 | Bus transaction of a slot completed |
| cmpl_idx | input | IDX_W | Slot that completed |
| cmpl_excl | input | 1 | Read completed with no other sharer |
| done_valid | output | 1 | Completion accepted, slot retires |
| done_addr | output | ADDR_W | Address of the retiring slot |
| done_state | output | 2 | Stable state: 1 S, 2 E, 3 M |
| commit_mask | output | DEPTH | Slots launched and not yet completed |

## Verification
The hardest cases are snoops that land in the same cycle as a grant, an enqueue or a completion. If the conversion were applied only at the edge, the head would launch as a stale upgrade while `bus_type` still showed 2 in the grant cycle. Duplicate and full tests are aimed at slots that free up in the same cycle. A design that judged them on next-state values would accept a request the rule refuses, or would place it in the wrong slot. Random traffic over a small address set fills the queue and repeats addresses. It also sends completions to unlaunched and empty slots, where a careless design would retire an entry early or report a bogus stable state.

// File: rtl/pq_pkg.sv
package pq_pkg;

    typedef enum logic [1:0] {
        REQ_RD  = 2'd0,
        REQ_RDX = 2'd1,
        REQ_UPG = 2'd2
    } req_e;

    typedef enum logic [1:0] {
        TR_I2S = 2'd0,
        TR_I2M = 2'd1,
        TR_S2M = 2'd2
    } trans_e;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } stable_e;

    function automatic trans_e trans_of(input req_e r);
        case (r)
            REQ_RDX: trans_of = TR_I2M;
            REQ_UPG: trans_of = TR_S2M;
            default: trans_of = TR_I2S;
        endcase
    endfunction

endpackage

// File: rtl/pq_match.sv
module pq_match #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 26
) (
    input  logic [DEPTH-1:0]             valid,
    input  logic [DEPTH-1:0][ADDR_W-1:0] addrs,
    input  logic [ADDR_W-1:0]            key,
    output logic [DEPTH-1:0]             hit
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = valid[g] && (addrs[g] == key);
    end

endmodule

// File: rtl/pq_alloc.sv
module pq_alloc #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] valid,
    output logic [IDX_W-1:0] free_idx,
    output logic             full
);

    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
        full = &valid;
    end

endmodule

// File: rtl/pq_order.sv
module pq_order #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CW    = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic             empty
);

    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0] slot;
        logic [IDX_W-1:0]            wr;
        logic [IDX_W-1:0]            rd;
        logic [CW-1:0]               cnt;
    } ord_t;

    ord_t ord_q, ord_d;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        bump = (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ord_d = ord_q;
        if (push) begin
            ord_d.slot[ord_q.wr] = push_idx;
            ord_d.wr             = bump(ord_q.wr);
        end
        if (pop) begin
            ord_d.rd = bump(ord_q.rd);
        end
        ord_d.cnt = ord_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ord_q <= '0;
        else        ord_q <= ord_d;
    end

    assign head_idx = ord_q.slot[ord_q.rd];
    assign empty    = (ord_q.cnt == '0);

endmodule

// File: rtl/pend_req_queue.sv
module pend_req_queue
    import pq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 26,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [1:0]        enq_type,
    output logic              enq_accept,
    output logic              enq_busy,
    output logic [IDX_W-1:0]  enq_idx,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_type,
    output logic [1:0]        bus_trans,
    output logic [IDX_W-1:0]  bus_idx,
    input  logic              bus_grant,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [1:0]        snoop_type,
    output logic              snoop_hit,
    output logic              snoop_inval,
    input  logic              cmpl_valid,
    input  logic [IDX_W-1:0]  cmpl_idx,
    input  logic              cmpl_excl,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_addr,
    output logic [1:0]        done_state,
    output logic [DEPTH-1:0]  commit_mask
);

    typedef struct packed {
        logic              valid;
        logic              launched;
        logic [ADDR_W-1:0] addr;
        req_e              rtype;
        trans_e            trans;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
    } state_t;

    state_t st_q, st_d;

    logic [DEPTH-1:0]             valid_vec;
    logic [DEPTH-1:0]             launched_vec;
    logic [DEPTH-1:0][ADDR_W-1:0] addr_vec;
    logic [DEPTH-1:0]             snp_match;
    logic [DEPTH-1:0]             dup_match;
    logic [DEPTH-1:0]             conv_vec;
    logic [IDX_W-1:0]             free_idx;
    logic                         full;
    logic [IDX_W-1:0]             head_idx;
    logic                         ord_empty;
    logic                         grant_fire;
    logic                         snoop_excl;
    logic                         cmpl_ok;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            valid_vec[i]    = st_q.ent[i].valid;
            launched_vec[i] = st_q.ent[i].launched;
            addr_vec[i]     = st_q.ent[i].addr;
        end
    end

    pq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_snoop_cam (
        .valid (valid_vec),
        .addrs (addr_vec),
        .key   (snoop_addr),
        .hit   (snp_match)
    );

    pq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dup_cam (
        .valid (valid_vec),
        .addrs (addr_vec),
        .key   (enq_addr),
        .hit   (dup_match)
    );

    pq_alloc #(.DEPTH(DEPTH)) u_alloc (
        .valid    (valid_vec),
        .free_idx (free_idx),
        .full     (full)
    );

    pq_order #(.DEPTH(DEPTH)) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (enq_accept),
        .push_idx (free_idx),
        .pop      (grant_fire),
        .head_idx (head_idx),
        .empty    (ord_empty)
    );

    // Inbound path: combinational on stored entries, independent of the arbiter.
    always_comb begin
        snoop_excl = snoop_valid &&
                     (snoop_type == REQ_UPG || snoop_type == REQ_RDX);
        for (int i = 0; i < DEPTH; i++) begin
            conv_vec[i] = snoop_excl && snp_match[i] && !launched_vec[i] &&
                          (st_q.ent[i].rtype == REQ_UPG);
        end
        snoop_hit   = snoop_valid && (|snp_match);
        snoop_inval = |conv_vec;
    end

    // Outbound path: head of the issue order, with same-cycle conversion folded in.
    always_comb begin
        bus_req    = !ord_empty;
        bus_idx    = head_idx;
        bus_addr   = st_q.ent[head_idx].addr;
        bus_type   = conv_vec[head_idx] ? REQ_RDX : st_q.ent[head_idx].rtype;
        bus_trans  = conv_vec[head_idx] ? TR_I2M  : st_q.ent[head_idx].trans;
        grant_fire = bus_req && bus_grant;
    end

    always_comb begin
        enq_accept = enq_valid && !full && !(|dup_match);
        enq_busy   = enq_valid && !enq_accept;
        enq_idx    = free_idx;
    end

    always_comb begin
        cmpl_ok    = cmpl_valid && st_q.ent[cmpl_idx].valid &&
                     st_q.ent[cmpl_idx].launched;
        done_valid = cmpl_ok;
        done_addr  = st_q.ent[cmpl_idx].addr;
        if (st_q.ent[cmpl_idx].rtype != REQ_RD) done_state = ST_M;
        else if (cmpl_excl)                     done_state = ST_E;
        else                                    done_state = ST_S;
        commit_mask = launched_vec;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (conv_vec[i]) begin
                st_d.ent[i].rtype = REQ_RDX;
                st_d.ent[i].trans = TR_I2M;
            end
            if (grant_fire && head_idx == IDX_W'(i)) begin
                st_d.ent[i].launched = 1'b1;
            end
            if (cmpl_ok && cmpl_idx == IDX_W'(i)) begin
                st_d.ent[i].valid    = 1'b0;
                st_d.ent[i].launched = 1'b0;
            end
            if (enq_accept && free_idx == IDX_W'(i)) begin
                st_d.ent[i].valid    = 1'b1;
                st_d.ent[i].launched = 1'b0;
                st_d.ent[i].addr     = enq_addr;
                st_d.ent[i].rtype    = req_e'(enq_type);
                st_d.ent[i].trans    = trans_of(req_e'(enq_type));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pend_req_queue_chk.sv
module pend_req_queue_chk #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enq_valid,
    input logic             enq_accept,
    input logic             enq_busy,
    input logic             bus_req,
    input logic [IDX_W-1:0] bus_idx,
    input logic             bus_grant,
    input logic             snoop_valid,
    input logic             snoop_hit,
    input logic             snoop_inval,
    input logic             cmpl_valid,
    input logic [IDX_W-1:0] cmpl_idx,
    input logic             done_valid,
    input logic [1:0]       done_state,
    input logic [DEPTH-1:0] commit_mask
);

    logic             gnt_q;
    logic [IDX_W-1:0] gnt_idx_q;
    logic             dn_q;
    logic [IDX_W-1:0] dn_idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q     <= 1'b0;
            gnt_idx_q <= '0;
            dn_q      <= 1'b0;
            dn_idx_q  <= '0;
        end else begin
            gnt_q     <= bus_req && bus_grant;
            gnt_idx_q <= bus_idx;
            dn_q      <= done_valid;
            dn_idx_q  <= cmpl_idx;
        end
    end

    assert_accept_busy_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(enq_accept && enq_busy));

    assert_busy_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_busy || enq_accept) |-> enq_valid);

    assert_head_unlaunched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !commit_mask[bus_idx]);

    assert_hit_needs_snoop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_hit |-> snoop_valid);

    assert_inval_is_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_inval |-> snoop_hit);

    assert_grant_commits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_q |-> commit_mask[gnt_idx_q]);

    assert_done_only_launched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (cmpl_valid && commit_mask[cmpl_idx] && done_state != 2'd0));

    assert_done_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_q |-> !commit_mask[dn_idx_q]);

    assert_ignore_unlaunched_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_mask[cmpl_idx] |-> !done_valid);

endmodule

bind pend_req_queue pend_req_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enq_valid   (enq_valid),
    .enq_accept  (enq_accept),
    .enq_busy    (enq_busy),
    .bus_req     (bus_req),
    .bus_idx     (bus_idx),
    .bus_grant   (bus_grant),
    .snoop_valid (snoop_valid),
    .snoop_hit   (snoop_hit),
    .snoop_inval (snoop_inval),
    .cmpl_valid  (cmpl_valid),
    .cmpl_idx    (cmpl_idx),
    .done_valid  (done_valid),
    .done_state  (done_state),
    .commit_mask (commit_mask)
);

// File: tb/pend_req_queue_bench.sv
module pend_req_queue_bench;

    localparam int DEPTH  = 16;
    localparam int ADDR_W = 26;
    localparam int IDX_W  = 4;

    logic              clk;
    logic              rst_n;
    logic              enq_valid;
    logic [ADDR_W-1:0] enq_addr;
    logic [1:0]        enq_type;
    logic              enq_accept;
    logic              enq_busy;
    logic [IDX_W-1:0]  enq_idx;
    logic              bus_req;
    logic [ADDR_W-1:0] bus_addr;
    logic [1:0]        bus_type;
    logic [1:0]        bus_trans;
    logic [IDX_W-1:0]  bus_idx;
    logic              bus_grant;
    logic              snoop_valid;
    logic [ADDR_W-1:0] snoop_addr;
    logic [1:0]        snoop_type;
    logic              snoop_hit;
    logic              snoop_inval;
    logic              cmpl_valid;
    logic [IDX_W-1:0]  cmpl_idx;
    logic              cmpl_excl;
    logic              done_valid;
    logic [ADDR_W-1:0] done_addr;
    logic [1:0]        done_state;
    logic [DEPTH-1:0]  commit_mask;

    pend_req_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_pend_req_queue (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_type(enq_type),
        .enq_accept(enq_accept), .enq_busy(enq_busy), .enq_idx(enq_idx),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_type(bus_type),
        .bus_trans(bus_trans), .bus_idx(bus_idx), .bus_grant(bus_grant),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_type(snoop_type),
        .snoop_hit(snoop_hit), .snoop_inval(snoop_inval),
        .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .cmpl_excl(cmpl_excl),
        .done_valid(done_valid), .done_addr(done_addr), .done_state(done_state),
        .commit_mask(commit_mask)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Behavioural reference: per-slot flags plus an issue-order queue.
    bit                m_valid  [DEPTH];
    bit                m_launch [DEPTH];
    logic [ADDR_W-1:0] m_addr   [DEPTH];
    int                m_type   [DEPTH];
    int                m_order  [$];

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int trans_code(input int t);
        if (t == 1) return 1;
        if (t == 2) return 2;
        return 0;
    endfunction

    task automatic idle_inputs();
        enq_valid   = 0; enq_addr   = '0; enq_type   = '0;
        bus_grant   = 0;
        snoop_valid = 0; snoop_addr = '0; snoop_type = '0;
        cmpl_valid  = 0; cmpl_idx   = '0; cmpl_excl  = 0;
    endtask

    // Compare all outputs against the model, then advance model and clock.
    task automatic tick();
        int              cnt;
        int              free_slot;
        bit              dup;
        bit              e_acc;
        bit              cv [DEPTH];
        bit              e_hit;
        bit              e_inv;
        int              h;
        int              etype;
        bit              d_ok;
        int              ci;
        logic [DEPTH-1:0] e_mask;
        #1;
        cnt = 0; free_slot = -1; dup = 0; e_hit = 0; e_inv = 0; e_mask = '0;
        for (int i = 0; i < DEPTH; i++) begin
            cv[i] = 0;
            if (m_valid[i]) begin
                cnt++;
                if (m_addr[i] == enq_addr) dup = 1;
                if (snoop_valid && m_addr[i] == snoop_addr) begin
                    e_hit = 1;
                    if (snoop_type != 0 && !m_launch[i] && m_type[i] == 2) begin
                        cv[i] = 1;
                        e_inv = 1;
                    end
                end
            end else if (free_slot < 0) begin
                free_slot = i;
            end
            e_mask[i] = m_launch[i];
        end
        e_acc = enq_valid && (cnt < DEPTH) && !dup;
        chk(e_acc ? "R2" : "R3", "enq_accept", enq_accept, e_acc);
        chk("R3", "enq_busy", enq_busy, enq_valid && !e_acc);
        if (e_acc) chk("R2", "enq_idx", enq_idx, free_slot);
        chk("R5", "snoop_hit", snoop_hit, e_hit);
        chk(e_inv ? "R6" : "R7", "snoop_inval", snoop_inval, e_inv);
        chk("R4", "bus_req", bus_req, m_order.size() > 0);
        chk("R8", "commit_mask", commit_mask, e_mask);
        h = -1;
        if (m_order.size() > 0) begin
            h = m_order[0];
            etype = cv[h] ? 1 : m_type[h];
            chk("R4", "bus_idx", bus_idx, h);
            chk("R4", "bus_addr", bus_addr, m_addr[h]);
            chk(cv[h] ? "R6" : "R4", "bus_type", bus_type, etype);
            chk(cv[h] ? "R6" : "R4", "bus_trans", bus_trans, trans_code(etype));
        end
        ci = int'(cmpl_idx);
        d_ok = cmpl_valid && m_valid[ci] && m_launch[ci];
        chk(d_ok ? "R9" : "R10", "done_valid", done_valid, d_ok);
        if (d_ok) begin
            chk("R9", "done_addr", done_addr, m_addr[ci]);
            chk("R9", "done_state", done_state,
                (m_type[ci] != 0) ? 3 : (cmpl_excl ? 2 : 1));
        end
        // model update at the edge, from pre-edge state
        for (int i = 0; i < DEPTH; i++) if (cv[i]) m_type[i] = 1;
        if (h >= 0 && bus_grant) begin
            m_launch[h] = 1;
            void'(m_order.pop_front());
        end
        if (d_ok) begin
            m_valid[ci]  = 0;
            m_launch[ci] = 0;
        end
        if (e_acc) begin
            m_valid[free_slot]  = 1;
            m_launch[free_slot] = 0;
            m_addr[free_slot]   = enq_addr;
            m_type[free_slot]   = int'(enq_type);
            m_order.push_back(free_slot);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enq(input int a, input int t);
        enq_valid = 1; enq_addr = ADDR_W'(a); enq_type = 2'(t);
        tick();
        idle_inputs();
    endtask

    task automatic snoop(input int a, input int t, input bit g);
        snoop_valid = 1; snoop_addr = ADDR_W'(a); snoop_type = 2'(t); bus_grant = g;
        tick();
        idle_inputs();
    endtask

    task automatic cmpl(input int idx, input bit ex);
        cmpl_valid = 1; cmpl_idx = IDX_W'(idx); cmpl_excl = ex;
        tick();
        idle_inputs();
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 0; m_launch[i] = 0; m_addr[i] = '0; m_type[i] = 0;
        end
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: idle after reset, snoop of address 0 must miss
        snoop(0, 2, 1);
        tick();
        // R2: three requests land in slots 0..2
        enq(16'h100, 0);
        enq(16'h101, 2);
        enq(16'h102, 1);
        // R3: duplicate address refused
        enq(16'h101, 1);
        // R7: read snoop on upgrade, upgrade snoop on read: hit only
        snoop(16'h101, 0, 0);
        snoop(16'h100, 2, 0);
        snoop(16'h1ff, 1, 0);
        // R8: launch the read, then R7 snoop on a launched slot
        snoop(16'h1fe, 0, 1);
        snoop(16'h100, 1, 0);
        // R10: completion for unlaunched slot 2 and for empty slot 9
        cmpl(2, 0);
        cmpl(9, 1);
        // R9: read completes exclusive
        cmpl(0, 1);
        // R6: remote upgrade hits pending upgrade at head, grant same cycle
        snoop(16'h101, 2, 1);
        cmpl(1, 0);
        // R6: conversion without grant, then later launch
        enq(16'h200, 2);
        snoop(16'h200, 1, 0);
        snoop(16'h3ff, 0, 1);
        snoop(16'h3ff, 0, 1);
        cmpl(0, 1);
        cmpl(1, 0);
        cmpl(2, 0);
        // R3: fill to full, then overflow refused; R5 snoops hit while full
        for (int k = 0; k < DEPTH; k++) enq(16'h400 + k, k % 3);
        enq(16'h4ff, 0);
        snoop(16'h40f, 2, 0);
        snoop(16'h402, 0, 0);
        // drain: grant all, complete out of order
        for (int k = 0; k < DEPTH; k++) begin
            bus_grant = 1;
            tick();
            idle_inputs();
        end
        for (int k = DEPTH - 1; k >= 0; k--) cmpl(k, k[0]);
        // random mixed traffic, two grant rates
        for (int k = 0; k < 3000; k++) begin
            enq_valid   = ($urandom % 2) == 0;
            enq_addr    = ADDR_W'($urandom % 24);
            enq_type    = 2'($urandom % 3);
            snoop_valid = ($urandom % 2) == 0;
            snoop_addr  = ADDR_W'($urandom % 24);
            snoop_type  = 2'($urandom % 3);
            bus_grant   = (k < 1500) ? (($urandom % 3) == 0) : (($urandom % 8) == 0);
            cmpl_valid  = ($urandom % 2) == 0;
            cmpl_idx    = IDX_W'($urandom % DEPTH);
            cmpl_excl   = ($urandom % 2) == 0;
            tick();
        end
        idle_inputs();
        tick();
        report();
    end

endmodule